// File: doc/BRIEF.md
# CRC16 Block Write Packetizer

The block turns one block-write payload into a sequence of SPI data packets and then checks the peripheral's acknowledgement. The payload arrives as a valid/ready byte stream. The block cuts it into packets of a programmable power-of-two size. Each packet starts with a header byte that tells the receiver whether it is the first, an inner or the last packet. When CRC protection is on, a CRC16 trailer follows the packet body.

The block waits for no response between packets. When the last byte has gone out, it reads exactly four bytes back. It searches them backwards for the most recent response tag and reports success or failure with a one-cycle `done` pulse. Issuing the block-write command that comes before the packets is the job of the surrounding logic. That logic pulses `start` with the byte count, the size exponent and the CRC enable, then feeds the payload.

Top module: `spi_pkt_writer`

## Requirements
- R1: The packet size is 2^(8+n) bytes, where n is `size_exp` sampled at start. Any value above 5 is treated as 5, so sizes run from 256 to 8192 bytes.
- R2: Every packet begins with one header byte 0xF0|code. Code 3 marks the final packet, including a payload that fits in a single packet. Code 1 marks the first of several packets and code 2 marks an inner packet.
- R3: Each packet body carries min(bytes still to send, packet size) payload bytes, taken from the payload stream in order.
- R4: With `crc_en` set at start, two bytes follow each packet body: the high byte first, then the low byte. They hold a CRC16 with polynomial 0x1021 and no final XOR, computed MSB-first over that packet's body only, starting from 0xFFFF for every packet. With `crc_en` clear, no trailer is sent.
- R5: `rx_ready` stays low until the last byte of the last packet has been accepted on the tx stream.
- R6: After the packets, exactly four response bytes are taken. Byte 0 is the first one received. The block searches indexes 2, 1 and 0, in that order, for the first byte whose upper nibble is 0xC.
- R7: `err` is reported low only when such a byte is found, its lower nibble is 3, and the byte at the next index is 0x00. In every other case, including when no tag is found, `err` is reported high.
- R8: A start with `total_len` of 4 or less sends nothing. It reports `done` with `err` high on the cycle after start.
- R9: `done` is a one-cycle pulse, and `err` is valid with it. `busy` is high from an accepted start until `done`. A `start` while busy is ignored.
- R10: After reset, `busy`, `done`, `tx_valid`, `pl_ready` and `rx_ready` are low.
- R11: A header or CRC byte offered on the tx stream holds its value until `tx_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block write (pulse) |
| total_len | input | LEN_W | Payload byte count |
| size_exp | input | 3 | Packet size exponent n |
| crc_en | input | 1 | Append CRC16 trailers |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte accepted |
| tx_valid | output | 1 | SPI transmit byte valid |
| tx_data | output | 8 | SPI transmit byte |
| tx_ready | input | 1 | SPI transmit byte taken |
| rx_valid | input | 1 | SPI receive byte valid |
| rx_data | input | 8 | SPI receive byte |
| rx_ready | output | 1 | Response byte accepted |
| busy | output | 1 | Write in progress |
| done | output | 1 | Write finished (pulse) |
| err | output | 1 | Failure status, valid with done |

## Verification
The bench builds the block with the default `LEN_W` of 16. That width lets a payload of 8193 bytes reach the largest packet size, so a full 8192-byte first packet followed by a one-byte final packet can be exercised. The same run covers a size exponent above 5 being clamped. The random transactions stay at exponents 0 to 2 and lengths up to 1200. This produces runs of first, inner and final packets with and without CRC, while directed response windows place the tag at every searched index and at the unsearched one.

// File: rtl/pkt_wr_pkg.sv
package pkt_wr_pkg;

    localparam int MIN_LOG  = 8;
    localparam int MAX_EXP  = 5;
    localparam int MIN_LEN  = 4;
    localparam logic [7:0] HDR_BASE = 8'hF0;
    localparam logic [3:0] RSP_TAG  = 4'hC;
    localparam logic [3:0] RSP_LAST = 4'h3;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_DATA, ST_CRC_HI, ST_CRC_LO, ST_RESP
    } wr_state_e;

    typedef enum logic [1:0] {
        ORD_FIRST = 2'd1, ORD_INNER = 2'd2, ORD_LAST = 2'd3
    } pkt_order_e;

    typedef logic [3:0][7:0] rsp_win_t;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

    function automatic logic rsp_good(input rsp_win_t w);
        logic       hit;
        logic [1:0] at;
        hit = 1'b0;
        at  = 2'd0;
        for (int i = 2; i >= 0; i--) begin
            if (!hit && w[i][7:4] == RSP_TAG) begin
                hit = 1'b1;
                at  = 2'(i);
            end
        end
        return hit && (w[at][3:0] == RSP_LAST) && (w[at + 2'd1] == 8'h00);
    endfunction

endpackage

// File: rtl/pkt_crc16.sv
module pkt_crc16 import pkt_wr_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  logic        seed,
    input  logic        adv,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst)       crc <= CRC_SEED;
        else if (seed) crc <= CRC_SEED;
        else if (adv)  crc <= crc16_step(crc, din);
    end

    // R4: every packet starts its checksum from the seed value
    p_seed_r4: assert property (@(posedge clk) disable iff (rst)
        seed |=> crc == CRC_SEED);
endmodule

// File: rtl/pkt_resp_check.sv
module pkt_resp_check import pkt_wr_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] din,
    output logic       fire,
    output logic       ok
);
    logic [1:0]      cnt_q;
    logic [2:0][7:0] held_q;
    rsp_win_t        win;

    assign fire = push && (cnt_q == 2'd3);
    assign win  = {din, held_q[2], held_q[1], held_q[0]};
    assign ok   = rsp_good(win);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            held_q <= '0;
        end else if (push) begin
            cnt_q <= cnt_q + 2'd1;
            if (cnt_q != 2'd3) held_q[cnt_q] <= din;
        end
    end

    // R6: the window restarts after exactly four bytes
    p_win_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        fire |=> cnt_q == 2'd0);
endmodule

// File: rtl/spi_pkt_writer.sv
module spi_pkt_writer import pkt_wr_pkg::*; #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    input  logic [2:0]       size_exp,
    input  logic             crc_en,
    input  logic             pl_valid,
    input  logic [7:0]       pl_data,
    output logic             pl_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam int PKT_W = MIN_LOG + MAX_EXP + 1;
    localparam int CW    = (LEN_W > PKT_W) ? LEN_W : PKT_W;

    wr_state_e        st_q;
    logic [2:0]       exp_q;
    logic             crc_on_q, first_q, done_q, err_q;
    logic [LEN_W-1:0] rem_q;
    logic [PKT_W-1:0] left_q;
    logic [CW-1:0]    size_c, rem_c;
    logic             last_pkt, tx_hs;
    pkt_order_e       order;
    logic [15:0]      crc;
    logic             rsp_fire, rsp_ok;
    logic [2:0]       exp_in;

    assign exp_in   = (size_exp > 3'(MAX_EXP)) ? 3'(MAX_EXP) : size_exp;
    assign size_c   = CW'(1) << (MIN_LOG + int'(exp_q));
    assign rem_c    = CW'(rem_q);
    assign last_pkt = rem_c <= size_c;
    assign order    = last_pkt ? ORD_LAST : (first_q ? ORD_FIRST : ORD_INNER);

    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        case (st_q)
            ST_HDR:    begin tx_valid = 1'b1;     tx_data = HDR_BASE | {6'd0, order}; end
            ST_DATA:   begin tx_valid = pl_valid; tx_data = pl_data;     end
            ST_CRC_HI: begin tx_valid = 1'b1;     tx_data = crc[15:8];   end
            ST_CRC_LO: begin tx_valid = 1'b1;     tx_data = crc[7:0];    end
            default:   ;
        endcase
    end

    assign tx_hs    = tx_valid && tx_ready;
    assign pl_ready = (st_q == ST_DATA) && tx_ready;
    assign rx_ready = (st_q == ST_RESP);
    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;

    pkt_crc16 u_crc (
        .clk (clk),
        .rst (rst),
        .seed(st_q == ST_HDR && tx_hs),
        .adv (st_q == ST_DATA && tx_hs),
        .din (pl_data),
        .crc (crc)
    );

    pkt_resp_check u_rsp (
        .clk (clk),
        .rst (rst),
        .push(rx_ready && rx_valid),
        .din (rx_data),
        .fire(rsp_fire),
        .ok  (rsp_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            exp_q    <= '0;
            crc_on_q <= 1'b0;
            first_q  <= 1'b0;
            rem_q    <= '0;
            left_q   <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (start) begin
                    if (total_len <= LEN_W'(MIN_LEN)) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        st_q     <= ST_HDR;
                        exp_q    <= exp_in;
                        crc_on_q <= crc_en;
                        rem_q    <= total_len;
                        first_q  <= 1'b1;
                    end
                end
                ST_HDR: if (tx_hs) begin
                    left_q  <= last_pkt ? PKT_W'(rem_q) : PKT_W'(size_c);
                    first_q <= 1'b0;
                    st_q    <= ST_DATA;
                end
                ST_DATA: if (tx_hs) begin
                    rem_q  <= rem_q - LEN_W'(1);
                    left_q <= left_q - PKT_W'(1);
                    if (left_q == PKT_W'(1)) begin
                        if (crc_on_q)                st_q <= ST_CRC_HI;
                        else if (rem_q == LEN_W'(1)) st_q <= ST_RESP;
                        else                         st_q <= ST_HDR;
                    end
                end
                ST_CRC_HI: if (tx_hs) st_q <= ST_CRC_LO;
                ST_CRC_LO: if (tx_hs) st_q <= (rem_q == '0) ? ST_RESP : ST_HDR;
                ST_RESP: if (rsp_fire) begin
                    done_q <= 1'b1;
                    err_q  <= !rsp_ok;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R5: responses are taken only once the payload is exhausted
    p_rsp_late_r5: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> rem_q == '0);
    // R3: a packet body never exceeds the packet size or the remaining bytes
    p_left_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA) |-> (left_q != '0) && (CW'(left_q) <= rem_c) && (CW'(left_q) <= size_c));
    // R8: short payloads are refused at once
    p_reject_r8: assert property (@(posedge clk) disable iff (rst)
        (start && st_q == ST_IDLE && total_len <= LEN_W'(MIN_LEN)) |=> done && err && !busy);
    // R9: done lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R11: locally generated bytes hold while stalled
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && st_q != ST_DATA) |=> tx_valid && $stable(tx_data));
endmodule

// File: tb/test_spi_pkt_writer.sv
module test_spi_pkt_writer;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] total_len;
    logic [2:0]  size_exp;
    logic        crc_en;
    logic        pl_valid;
    logic [7:0]  pl_data;
    logic        pl_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_ready;
    logic        busy, done, err;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    spi_pkt_writer #(.LEN_W(16)) i_spi_pkt_writer (
        .clk(clk), .rst(rst), .start(start), .total_len(total_len),
        .size_exp(size_exp), .crc_en(crc_en), .pl_valid(pl_valid),
        .pl_data(pl_data), .pl_ready(pl_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .busy(busy), .done(done),
        .err(err)
    );

    logic [7:0] pay[$];
    logic [7:0] want[$];
    logic [7:0] got[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int b = 7; b >= 0; b--) begin
            logic fb = r[15] ^ d[b];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    function automatic bit m_rsp_err(input logic [7:0] r0, r1, r2, r3);
        logic [7:0] w[4];
        w[0] = r0; w[1] = r1; w[2] = r2; w[3] = r3;
        for (int i = 2; i >= 0; i--)
            if (w[i][7:4] == 4'hC)
                return !(w[i][3:0] == 4'h3 && w[i+1] == 8'h00);
        return 1'b1;
    endfunction

    task automatic build_want(input int len, input int ex, input bit c);
        int psz = 1 << (8 + ((ex > 5) ? 5 : ex));
        int rem = len;
        int idx = 0;
        bit first = 1'b1;
        want.delete();
        if (len <= 4) return;
        while (rem > 0) begin
            int n = (rem < psz) ? rem : psz;
            logic [15:0] cr = 16'hFFFF;
            want.push_back(8'hF0 | ((rem <= psz) ? 8'd3 : (first ? 8'd1 : 8'd2)));
            first = 1'b0;
            for (int k = 0; k < n; k++) begin
                want.push_back(pay[idx]);
                cr = m_crc(cr, pay[idx]);
                idx++;
            end
            if (c) begin
                want.push_back(cr[15:8]);
                want.push_back(cr[7:0]);
            end
            rem -= n;
        end
    endtask

    task automatic run_txn(input int len, input int ex, input bit c,
                           input logic [7:0] r0, r1, r2, r3,
                           input string tag, input bit poke);
        int pidx = 0, ridx = 0, early = 0, cyc = 0, bad = 0;
        bit seen = 1'b0, e_got = 1'b0, two = 1'b0;
        logic [7:0] rs[4];
        rs[0] = r0; rs[1] = r1; rs[2] = r2; rs[3] = r3;
        pay.delete(); got.delete();
        for (int k = 0; k < len; k++) pay.push_back(8'($urandom));
        build_want(len, ex, c);
        while (!seen && cyc < 40000) begin
            @(negedge clk);
            start     = (cyc == 0) || (poke && cyc == 5);
            total_len = (cyc == 0) ? 16'(len) : 16'd3;
            size_exp  = 3'(ex);
            crc_en    = c;
            pl_valid  = pidx < len;
            pl_data   = (pidx < len) ? pay[pidx] : 8'h00;
            tx_ready  = ($urandom % 4) != 0;
            rx_valid  = (ridx < 4) && (($urandom % 3) != 0);
            rx_data   = (ridx < 4) ? rs[ridx] : 8'h00;
            #1;
            if (done) begin seen = 1'b1; e_got = err; end
            if (tx_valid && tx_ready) got.push_back(tx_data);
            if (pl_valid && pl_ready) pidx++;
            if (rx_valid && rx_ready) begin
                if (got.size() != want.size()) early++;
                ridx++;
            end
            cyc++;
        end
        start = 1'b0; pl_valid = 1'b0; rx_valid = 1'b0;
        check(seen, {tag, " done seen"}, seen, 1);
        for (int k = 0; k < want.size(); k++)
            if (k >= got.size() || got[k] !== want[k]) bad++;
        check(bad == 0 && got.size() == want.size(), {tag, " tx stream"}, got.size(), want.size());
        if (len > 4) begin
            check(e_got == m_rsp_err(r0, r1, r2, r3), {tag, " R7 err"}, e_got, m_rsp_err(r0, r1, r2, r3));
            check(ridx == 4, {tag, " R6 rsp count"}, ridx, 4);
            check(early == 0, {tag, " R5 rx early"}, early, 0);
        end else begin
            check(e_got == 1'b1, {tag, " R8 reject err"}, e_got, 1);
        end
        @(negedge clk); #1;
        two = done;
        check(!two && !busy, {tag, " R9 single pulse"}, two, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        rst = 1'b1; start = 1'b0; total_len = '0; size_exp = '0; crc_en = 1'b0;
        pl_valid = 1'b0; pl_data = '0; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        check(!busy && !done && !tx_valid && !pl_ready && !rx_ready, "R10 reset",
              {busy, done, tx_valid, pl_ready, rx_ready}, 0);
        @(negedge clk);
        rst = 1'b0;

        run_txn(4,   0, 1, 8'hC3, 8'h00, 8'h00, 8'h00, "R8 len4", 0);
        run_txn(0,   0, 0, 8'hC3, 8'h00, 8'h00, 8'h00, "R8 len0", 0);
        run_txn(5,   0, 1, 8'hC3, 8'h00, 8'h55, 8'h55, "R3 len5", 0);
        run_txn(256, 0, 1, 8'hC3, 8'h00, 8'h00, 8'h00, "R2 single", 0);
        run_txn(257, 0, 0, 8'h00, 8'hC3, 8'h00, 8'h12, "R2 two", 0);
        run_txn(700, 0, 1, 8'hC1, 8'h00, 8'hC3, 8'h00, "R4 three", 0);
        run_txn(600, 1, 0, 8'hC3, 8'h00, 8'hC1, 8'h00, "R1 exp1", 0);
        run_txn(8193, 7, 1, 8'h00, 8'h00, 8'hC3, 8'h00, "R1 clamp", 0);
        run_txn(40,  0, 0, 8'h00, 8'h00, 8'h00, 8'hC3, "R6 untagged", 0);
        run_txn(40,  0, 1, 8'hC3, 8'h05, 8'h00, 8'h00, "R7 status", 0);
        run_txn(40,  0, 0, 8'hC2, 8'h00, 8'h00, 8'h00, "R7 kind", 0);
        run_txn(300, 0, 1, 8'hC3, 8'h00, 8'h00, 8'h00, "R9 busy start", 1);

        for (int t = 0; t < 12; t++) begin
            int l = 5 + ($urandom % 1196);
            int e = $urandom % 3;
            bit c = 1'($urandom);
            bit good = ($urandom % 3) != 0;
            if (good)
                run_txn(l, e, c, 8'($urandom), 8'hC3, 8'h00, 8'($urandom), "R3 rand", 0);
            else
                run_txn(l, e, c, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R7 rand", 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule